// File: doc/BRIEF.md
# Gain Tracking Loop Filter

This block performs the fine, slow gain correction that follows a coarse gain search in an amplitude control loop. A one-hot marker sits in a short shift register and acts as a digital low-pass filter. On every tracking clock the marker moves one place toward the upper end when the amplitude comparator reports "too large", and one place toward the lower end when it reports "too small". A single noisy decision therefore does not change the gain. The gain moves only when the marker is pushed past an end. At that point the block issues a one-cycle step pulse, adjusts an 8-unit fine thermometer code and puts the marker back in the centre so that filtering can resume.

The filter runs only while tracking is enabled. A small controller has two states. `ST_IDLE` freezes everything. `ST_TRACK` applies the comparator flags. The transition "enter" (`ST_IDLE` to `ST_TRACK`) is taken on the first clock edge that sees `track_en` high, and on that edge the marker is loaded to the centre. The transition "leave" (`ST_TRACK` to `ST_IDLE`) is taken on any edge that sees `track_en` low. While in `ST_TRACK`, the flag pair is decoded into one of three moves: up, down or hold.

Top module: `gain_track_filter`

## Requirements
- R1: After reset, `marker` is 8'h10 (bit 4, the centre), `fine_code` is 8'h0F (4 units), `step_up` and `step_down` are low, and the controller is in `ST_IDLE`.
- R2: `marker` always has exactly one bit set.
- R3: In `ST_TRACK`, `flag_large` alone moves the marker from bit i to bit i+1 on the next edge, and `flag_small` alone moves it from bit i to bit i-1.
- R4: In `ST_TRACK`, when both flags are low or both are high, the marker, `fine_code` and the step outputs stay unchanged or low.
- R5: `flag_large` alone with the marker at bit 7 is an overflow. On that edge the marker returns to bit 4 and the fine count drops by one. `step_down` is high for exactly the following cycle.
- R6: `flag_small` alone with the marker at bit 0 is an underflow. On that edge the marker returns to bit 4 and the fine count rises by one. `step_up` is high for exactly the following cycle.
- R7: `fine_code` is a thermometer code in which the lowest n bits are set for a count n in the range 0..8. An overflow at count 0, or an underflow at count 8, produces no pulse and leaves the count unchanged, but the marker still returns to bit 4.
- R8: While the controller is in `ST_IDLE` and `track_en` is low, the flags have no effect on the marker, `fine_code` or the step outputs.
- R9: The edge that takes the "enter" transition loads the marker to bit 4 and ignores the flags. The fine count is kept across leaving and re-entering tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tracking clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| track_en | input | 1 | High while the loop is in fine tracking |
| flag_large | input | 1 | Comparator: amplitude above upper threshold |
| flag_small | input | 1 | Comparator: amplitude below lower threshold |
| step_up | output | 1 | One-cycle request to raise gain by one step |
| step_down | output | 1 | One-cycle request to lower gain by one step |
| fine_code | output | 8 | Fine gain thermometer code |
| marker | output | 8 | One-hot filter position |

## Verification
Two functions meet on the same edge: the end-of-register wrap and the saturation of the fine count. When this happens the marker must recentre while the step request is dropped. The bench provokes this by driving long runs of one flag until the count is pinned at 0 or at 8 and the marker keeps cycling. It then checks on every cycle that the marker lands on bit 4 with no pulse and an unchanged code. The bench also places the entry edge, both-flags edges and idle edges at every marker position, and judges each cycle against an arithmetic model of position and count.

// File: rtl/gtf_pkg.sv
package gtf_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_TRACK = 1'b1
    } trk_state_t;

    typedef enum logic [1:0] {
        MV_HOLD = 2'b00,
        MV_UP   = 2'b01,
        MV_DOWN = 2'b10
    } move_t;

endpackage

// File: rtl/gtf_ctrl.sv
module gtf_ctrl
    import gtf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  track_en,
    input  logic  flag_large,
    input  logic  flag_small,
    output logic  load_centre,
    output move_t move
);

    trk_state_t state_q;
    trk_state_t state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        load_centre = 1'b0;
        move        = MV_HOLD;
        unique case (state_q)
            ST_IDLE: begin
                if (track_en) begin
                    state_d     = ST_TRACK;
                    load_centre = 1'b1;
                end
            end
            ST_TRACK: begin
                if (!track_en) begin
                    state_d = ST_IDLE;
                end else begin
                    unique case ({flag_large, flag_small})
                        2'b10:   move = MV_UP;
                        2'b01:   move = MV_DOWN;
                        default: move = MV_HOLD;
                    endcase
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R8: idle never moves the marker
    a_r8_idle_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (move == MV_HOLD));

    // R9: load happens only on entry
    a_r9_load_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        load_centre |=> (state_q == ST_TRACK));

endmodule

// File: rtl/gtf_shift.sv
module gtf_shift
    import gtf_pkg::*;
#(
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_centre,
    input  move_t            move,
    output logic [POS_W-1:0] pos,
    output logic             ovf,
    output logic             unf
);

    localparam int               CENTRE     = POS_W / 2;
    localparam logic [POS_W-1:0] CENTRE_VEC = POS_W'(1) << CENTRE;

    always_comb begin
        ovf = (move == MV_UP)   && pos[POS_W-1];
        unf = (move == MV_DOWN) && pos[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= CENTRE_VEC;
        end else if (load_centre || ovf || unf) begin
            pos <= CENTRE_VEC;
        end else begin
            unique case (move)
                MV_UP:   pos <= {pos[POS_W-2:0], 1'b0};
                MV_DOWN: pos <= {1'b0, pos[POS_W-1:1]};
                default: pos <= pos;
            endcase
        end
    end

    // R2: marker stays one-hot
    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pos) == 1);

    // R4: hold keeps marker
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (move == MV_HOLD && !load_centre) |=> $stable(pos));

    // R5 / R6: wrap recentres
    a_r5_wrap_centre: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf || unf) |=> (pos == CENTRE_VEC));

endmodule

// File: rtl/gtf_fine.sv
module gtf_fine #(
    parameter int FINE_W    = 8,
    parameter int FINE_INIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_dec,
    input  logic              req_inc,
    output logic [FINE_W-1:0] therm,
    output logic              step_up,
    output logic              step_down
);

    localparam int              CNT_W    = $clog2(FINE_W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FINE_W);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(FINE_INIT);

    logic [CNT_W-1:0] count;
    logic             can_inc;
    logic             can_dec;

    always_comb begin
        can_inc = req_inc && (count != CNT_MAX);
        can_dec = req_dec && (count != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count     <= CNT_INIT;
            step_up   <= 1'b0;
            step_down <= 1'b0;
        end else begin
            step_up   <= can_inc;
            step_down <= can_dec;
            if (can_inc) begin
                count <= count + 1'b1;
            end else if (can_dec) begin
                count <= count - 1'b1;
            end
        end
    end

    for (genvar i = 0; i < FINE_W; i++) begin : g_therm
        assign therm[i] = (count > CNT_W'(i));
    end

    // R7: count stays in range
    a_r7_range: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_MAX);

    // R5: a down pulse follows a decrement
    a_r5_down_dec: assert property (@(posedge clk) disable iff (!rst_n)
        step_down |-> (count == $past(count) - 1'b1));

    // R6: an up pulse follows an increment
    a_r6_up_inc: assert property (@(posedge clk) disable iff (!rst_n)
        step_up |-> (count == $past(count) + 1'b1));

    // R5 / R6: pulses never coincide
    a_r6_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_up && step_down));

endmodule

// File: rtl/gain_track_filter.sv
module gain_track_filter
    import gtf_pkg::*;
#(
    parameter int POS_W     = 8,
    parameter int FINE_W    = 8,
    parameter int FINE_INIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              track_en,
    input  logic              flag_large,
    input  logic              flag_small,
    output logic              step_up,
    output logic              step_down,
    output logic [FINE_W-1:0] fine_code,
    output logic [POS_W-1:0]  marker
);

    logic  load_centre;
    move_t move;
    logic  ovf;
    logic  unf;

    gtf_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .track_en    (track_en),
        .flag_large  (flag_large),
        .flag_small  (flag_small),
        .load_centre (load_centre),
        .move        (move)
    );

    gtf_shift #(.POS_W(POS_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_centre (load_centre),
        .move        (move),
        .pos         (marker),
        .ovf         (ovf),
        .unf         (unf)
    );

    gtf_fine #(.FINE_W(FINE_W), .FINE_INIT(FINE_INIT)) u_fine (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_dec   (ovf),
        .req_inc   (unf),
        .therm     (fine_code),
        .step_up   (step_up),
        .step_down (step_down)
    );

    // R8: no step request after a disabled edge
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !track_en |=> (!step_up && !step_down));

    // R4: both flags never produce a step
    a_r4_both_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_large && flag_small) |=> (!step_up && !step_down));

endmodule

// File: tb/gain_track_filter_tb_top.sv
`timescale 1ns/1ps
module gain_track_filter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       track_en = 1'b0;
    logic       flag_large = 1'b0;
    logic       flag_small = 1'b0;
    logic       step_up;
    logic       step_down;
    logic [7:0] fine_code;
    logic [7:0] marker;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    int m_track = 0;
    int m_pos = 4;
    int m_cnt = 4;
    int e_up = 0;
    int e_dn = 0;

    always #4 clk = ~clk;

    gain_track_filter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .track_en   (track_en),
        .flag_large (flag_large),
        .flag_small (flag_small),
        .step_up    (step_up),
        .step_down  (step_down),
        .fine_code  (fine_code),
        .marker     (marker)
    );

    function automatic logic [7:0] therm_of(input int n);
        logic [7:0] t = '0;
        for (int i = 0; i < 8; i++) if (i < n) t[i] = 1'b1;
        return t;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, marker, 8'(1 << m_pos), "marker");
        chk(tag, fine_code, therm_of(m_cnt), "fine_code");
        chk(tag, {7'd0, step_up}, 8'(e_up), "step_up");
        chk(tag, {7'd0, step_down}, 8'(e_dn), "step_down");
    endtask

    task automatic cyc(input bit en, input bit lg, input bit sm, input string tag);
        track_en = en; flag_large = lg; flag_small = sm;
        @(posedge clk);
        e_up = 0; e_dn = 0;
        if (m_track == 0) begin
            if (en) begin m_track = 1; m_pos = 4; end
        end else if (!en) begin
            m_track = 0;
        end else if (lg && !sm) begin
            if (m_pos == 7) begin
                m_pos = 4;
                if (m_cnt > 0) begin m_cnt--; e_dn = 1; end
            end else m_pos++;
        end else if (sm && !lg) begin
            if (m_pos == 0) begin
                m_pos = 4;
                if (m_cnt < 8) begin m_cnt++; e_up = 1; end
            end else m_pos--;
        end
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // idle: flags ignored (R8)
        cyc(0, 1, 0, "R8");
        cyc(0, 0, 1, "R8");
        cyc(0, 1, 1, "R8");

        // entry with flag ignored (R9)
        cyc(1, 1, 0, "R9");

        // walk up one step at a time (R3), hold between (R4)
        for (int i = 0; i < 3; i++) begin
            cyc(1, 1, 0, "R3");
            cyc(1, 0, 0, "R4");
            cyc(1, 1, 1, "R4");
        end
        cyc(1, 1, 0, "R5");
        // walk down to bit 0 then underflow (R6)
        for (int i = 0; i < 4; i++) cyc(1, 0, 1, "R3");
        cyc(1, 0, 1, "R6");
        cyc(1, 0, 0, "R6");

        // drive count to 0 and keep pushing: saturation with wrap (R7)
        for (int i = 0; i < 60; i++) cyc(1, 1, 0, "R7");
        // idle with marker off-centre, then re-entry (R8, R9)
        cyc(1, 1, 0, "R3");
        cyc(0, 0, 1, "R8");
        cyc(0, 1, 0, "R8");
        cyc(1, 0, 1, "R9");
        // drive count to 8 and beyond (R7, R6)
        for (int i = 0; i < 60; i++) cyc(1, 0, 1, "R7");

        // both flags at every position (R4)
        for (int p = 0; p < 8; p++) begin
            cyc(1, 1, 1, "R4");
            cyc(1, 1, 0, "R3");
        end

        // pseudo-random mix (R2..R9)
        lfsr = 16'hACE1;
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[3:0] != 4'h0, lfsr[5], lfsr[8], "R2");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule